// File: doc/BRIEF.md
# Stereo Serial Audio Receiver

This block takes a three-wire serial audio link and turns it into parallel stereo samples. The three wires are a bit clock, a word clock and a data line. All three pins are brought into the system clock domain through synchronizer chains. A rising edge of the bit clock is found by comparing the synchronized bit clock with its previous value, and each such edge samples one data bit. The block works out which channel a word belongs to from the word-clock level.

Two framings are supported:

- **Right-justified:** the word ends on the last bit before the word-clock changes level. The start of the word therefore moves with the configured word length.
- **I2S:** the most significant bit comes one bit period after the word-clock change.

Words are two's complement and arrive MSB first. Each word is sign-extended to 24 bits. Once a left word and the right word after it have both arrived, the pair is presented together with a one-cycle strobe.

Framing, word length and word-clock polarity are static inputs. They are changed only while the block is held in reset.

Top module: `stereo_pcm_rx`

## Requirements
- R1: While reset is high and in the cycle after it falls, `pair_valid` is 0 and both sample outputs read zero.
- R2: With `cfg_i2s`=0 (right-justified), a word is the last N bits sampled before the word-clock level changes. Any earlier bits in the same phase are discarded.
- R3: With `cfg_i2s`=1, the bit sampled at the first bit-clock rising edge after a word-clock change is skipped. The next N bits form the word, MSB first, and any further bits in that phase are ignored.
- R4: `cfg_wlen` selects N: 2'b00 gives 16, 2'b01 gives 20, 2'b10 gives 24, and the reserved code 2'b11 is treated as 24.
- R5: Each word is sign-extended from bit N-1 to 24 bits.
- R6: With `cfg_lr_swap`=0, a word sent while the word clock is high is the left sample and one sent while it is low is the right sample. With `cfg_lr_swap`=1 the mapping is reversed.
- R7: After a left word and then a right word, `pair_valid` is high for exactly one cycle. `left_out` and `right_out` change only in that cycle and hold their values otherwise.
- R8: Data is taken only at bit-clock rising edges. Changes on the data line while the bit clock is high have no effect.
- R9: A right word received with no left word pending after reset produces no `pair_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| aud_bck | input | 1 | Serial bit clock pin (asynchronous) |
| aud_ws | input | 1 | Word clock pin, one period per stereo frame |
| aud_sd | input | 1 | Serial data pin, MSB first |
| cfg_i2s | input | 1 | 0 = right-justified framing, 1 = I2S framing |
| cfg_wlen | input | 2 | Word length code (see R4) |
| cfg_lr_swap | input | 1 | Swap which word-clock level means left |
| left_out | output | 24 | Sign-extended left sample |
| right_out | output | 24 | Sign-extended right sample |
| pair_valid | output | 1 | One-cycle strobe when a new sample pair is presented |

## Verification
The bench builds the block with its default parameters:

- two synchronizer stages;
- a seven-bit slot counter.

The bench drives a bit clock of 32 system clocks per bit and 32-bit channel slots. This is enough to place filler bits before a right-justified word and after an I2S word at every word length, so the discarding in R2 and R3 is exercised.

The two-stage synchronizer gives the data line and the bit clock the same delay. This lets the bench put junk on the data line during the high phase of the bit clock and still expect clean words. The bench also starts each run in the right-channel phase, which brings the R9 case within reach.

// File: rtl/pcm_rx_pkg.sv
package pcm_rx_pkg;

  localparam int MAX_W = 24;
  localparam int IDX_W = $clog2(MAX_W);

  typedef enum logic [1:0] {
    WLEN_16  = 2'b00,
    WLEN_20  = 2'b01,
    WLEN_24  = 2'b10,
    WLEN_RSV = 2'b11
  } wlen_e;

  // Number of meaningful bits for a word length code; reserved maps to 24 (R4)
  function automatic int word_len(input logic [1:0] code);
    case (wlen_e'(code))
      WLEN_16: return 16;
      WLEN_20: return 20;
      default: return MAX_W;
    endcase
  endfunction

  // Keep the low n bits of raw and copy bit n-1 upward (R5)
  function automatic logic [MAX_W-1:0] sign_fill(input logic [MAX_W-1:0] raw, input int n);
    logic [MAX_W-1:0] res;
    logic [IDX_W-1:0] top_idx;
    top_idx = IDX_W'(n - 1);
    for (int i = 0; i < MAX_W; i++) begin
      res[i] = (i < n) ? raw[i] : raw[top_idx];
    end
    return res;
  endfunction

endpackage

// File: rtl/pcm_rx_sync.sv
module pcm_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic bck_in,
  input  logic ws_in,
  input  logic sd_in,
  output logic bit_rise,
  output logic ws_bit,
  output logic sd_bit
);

  localparam int NPINS = 3;

  logic [NPINS-1:0] pins;
  logic [NPINS-1:0] synced;
  logic             bck_last;

  assign pins = {sd_in, ws_in, bck_in};

  for (genvar g = 0; g < NPINS; g++) begin : g_chain
    logic [STAGES-1:0] ff;
    always_ff @(posedge clk) begin
      if (rst) ff <= '0;
      else     ff <= {ff[STAGES-2:0], pins[g]};
    end
    assign synced[g] = ff[STAGES-1];
  end

  always_ff @(posedge clk) begin
    if (rst) bck_last <= 1'b0;
    else     bck_last <= synced[0];
  end

  assign bit_rise = synced[0] & ~bck_last;
  assign ws_bit   = synced[1];
  assign sd_bit   = synced[2];

  // a rising edge needs a low sample between two highs
  assert_edge_gap_R8: assert property (@(posedge clk) disable iff (rst)
    bit_rise |=> !bit_rise);

endmodule

// File: rtl/pcm_rx_deframer.sv
module pcm_rx_deframer
  import pcm_rx_pkg::*;
#(
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_rise,
  input  logic             ws_bit,
  input  logic             sd_bit,
  input  logic             cfg_i2s,
  input  logic [1:0]       cfg_wlen,
  input  logic             cfg_lr_swap,
  output logic             word_stb,
  output logic [MAX_W-1:0] word_val,
  output logic             word_left
);

  localparam logic [CNT_W-1:0] CNT_SAT = {CNT_W{1'b1}};

  logic [MAX_W-1:0] sh;
  logic             ws_prev;
  logic             primed;
  logic [CNT_W-1:0] cnt;

  int               n;
  logic [CNT_W-1:0] n_cnt;
  logic             ws_flip;
  logic             rj_hit;
  logic             i2s_hit;
  logic [MAX_W-1:0] raw;
  logic             phase_ws;

  always_comb begin
    n        = word_len(cfg_wlen);
    n_cnt    = CNT_W'(n);
    ws_flip  = primed && (ws_bit != ws_prev);
    rj_hit   = bit_rise && !cfg_i2s && ws_flip;
    i2s_hit  = bit_rise && cfg_i2s && primed && !ws_flip && (cnt == n_cnt);
    raw      = cfg_i2s ? {sh[MAX_W-2:0], sd_bit} : sh;
    phase_ws = cfg_i2s ? ws_bit : ws_prev;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sh        <= '0;
      ws_prev   <= 1'b0;
      primed    <= 1'b0;
      cnt       <= CNT_SAT;
      word_stb  <= 1'b0;
      word_val  <= '0;
      word_left <= 1'b0;
    end else begin
      word_stb <= rj_hit | i2s_hit;
      if (rj_hit | i2s_hit) begin
        word_val  <= sign_fill(raw, n);
        word_left <= phase_ws ^ cfg_lr_swap;
      end
      if (bit_rise) begin
        sh      <= {sh[MAX_W-2:0], sd_bit};
        ws_prev <= ws_bit;
        primed  <= 1'b1;
        if (ws_flip)             cnt <= CNT_W'(1);
        else if (cnt != CNT_SAT) cnt <= cnt + 1'b1;
      end
    end
  end

  // right-justified words end only at a word-clock change
  assert_rj_end_R2: assert property (@(posedge clk) disable iff (rst)
    (bit_rise && !cfg_i2s && primed && (ws_bit == ws_prev)) |=> !word_stb);

  // the delay bit right after a change never completes an I2S word
  assert_i2s_delay_R3: assert property (@(posedge clk) disable iff (rst)
    (bit_rise && cfg_i2s && ws_flip) |=> !word_stb);

  assert_word_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    word_stb |=> !word_stb);

endmodule

// File: rtl/pcm_rx_pair.sv
module pcm_rx_pair
  import pcm_rx_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             word_stb,
  input  logic [MAX_W-1:0] word_val,
  input  logic             word_left,
  output logic [MAX_W-1:0] left_out,
  output logic [MAX_W-1:0] right_out,
  output logic             pair_valid
);

  logic [MAX_W-1:0] left_hold;
  logic             left_have;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_hold  <= '0;
      left_have  <= 1'b0;
      left_out   <= '0;
      right_out  <= '0;
      pair_valid <= 1'b0;
    end else begin
      pair_valid <= 1'b0;
      if (word_stb) begin
        if (word_left) begin
          left_hold <= word_val;
          left_have <= 1'b1;
        end else if (left_have) begin
          left_out   <= left_hold;
          right_out  <= word_val;
          pair_valid <= 1'b1;
          left_have  <= 1'b0;
        end
      end
    end
  end

  assert_pair_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    pair_valid |=> !pair_valid);

  assert_pair_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !pair_valid |-> ($stable(left_out) && $stable(right_out)));

  assert_need_left_R9: assert property (@(posedge clk) disable iff (rst)
    (word_stb && !word_left && !left_have) |=> !pair_valid);

endmodule

// File: rtl/stereo_pcm_rx.sv
module stereo_pcm_rx
  import pcm_rx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int CNT_W       = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             aud_bck,
  input  logic             aud_ws,
  input  logic             aud_sd,
  input  logic             cfg_i2s,
  input  logic [1:0]       cfg_wlen,
  input  logic             cfg_lr_swap,
  output logic [MAX_W-1:0] left_out,
  output logic [MAX_W-1:0] right_out,
  output logic             pair_valid
);

  logic             bit_rise;
  logic             ws_bit;
  logic             sd_bit;
  logic             word_stb;
  logic [MAX_W-1:0] word_val;
  logic             word_left;

  pcm_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .bck_in   (aud_bck),
    .ws_in    (aud_ws),
    .sd_in    (aud_sd),
    .bit_rise (bit_rise),
    .ws_bit   (ws_bit),
    .sd_bit   (sd_bit)
  );

  pcm_rx_deframer #(.CNT_W(CNT_W)) u_deframe (
    .clk         (clk),
    .rst         (rst),
    .bit_rise    (bit_rise),
    .ws_bit      (ws_bit),
    .sd_bit      (sd_bit),
    .cfg_i2s     (cfg_i2s),
    .cfg_wlen    (cfg_wlen),
    .cfg_lr_swap (cfg_lr_swap),
    .word_stb    (word_stb),
    .word_val    (word_val),
    .word_left   (word_left)
  );

  pcm_rx_pair u_pair (
    .clk        (clk),
    .rst        (rst),
    .word_stb   (word_stb),
    .word_val   (word_val),
    .word_left  (word_left),
    .left_out   (left_out),
    .right_out  (right_out),
    .pair_valid (pair_valid)
  );

  assert_sext16_R5: assert property (@(posedge clk) disable iff (rst)
    (pair_valid && cfg_wlen == 2'b00) |->
      (left_out[23:16] == {8{left_out[15]}} && right_out[23:16] == {8{right_out[15]}}));

  assert_sext20_R5: assert property (@(posedge clk) disable iff (rst)
    (pair_valid && cfg_wlen == 2'b01) |->
      (left_out[23:20] == {4{left_out[19]}} && right_out[23:20] == {4{right_out[19]}}));

endmodule

// File: tb/sim_stereo_pcm_rx.sv
module sim_stereo_pcm_rx;

  localparam int HALF = 16;
  localparam int SLOT = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        aud_bck = 1'b0;
  logic        aud_ws = 1'b0;
  logic        aud_sd = 1'b0;
  logic        cfg_i2s = 1'b0;
  logic [1:0]  cfg_wlen = 2'b00;
  logic        cfg_lr_swap = 1'b0;
  logic [23:0] left_out;
  logic [23:0] right_out;
  logic        pair_valid;

  int          n_run = 0;
  int          n_fail = 0;
  bit          junk = 1'b0;
  bit          done = 1'b0;
  string       cur_req = "R1";
  logic [47:0] exp_q[$];

  always #2 clk = ~clk;

  stereo_pcm_rx u0 (
    .clk         (clk),
    .rst         (rst),
    .aud_bck     (aud_bck),
    .aud_ws      (aud_ws),
    .aud_sd      (aud_sd),
    .cfg_i2s     (cfg_i2s),
    .cfg_wlen    (cfg_wlen),
    .cfg_lr_swap (cfg_lr_swap),
    .left_out    (left_out),
    .right_out   (right_out),
    .pair_valid  (pair_valid)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [23:0] act, input logic [23:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  // sign extension of the low n bits, R5
  function automatic logic [23:0] ext(input logic [23:0] w, input int n);
    logic signed [23:0] t;
    t = signed'(w << (24 - n));
    return t >>> (24 - n);
  endfunction

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && pair_valid) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R9", "unexpected pair strobe", left_out, 24'h0);
      end else begin
        logic [47:0] e;
        e = exp_q.pop_front();
        check(left_out == e[47:24], cur_req, "left sample", left_out, e[47:24]);
        check(right_out == e[23:0], cur_req, "right sample", right_out, e[23:0]);
      end
    end
  end

  // one bit period; data settles mid-low, R8 junk mode scrambles the high phase
  task automatic send_bit(input logic ws, input logic d);
    aud_bck = 1'b0;
    aud_ws  = ws;
    aud_sd  = junk ? ~d : d;
    repeat (HALF / 2) @(negedge clk);
    aud_sd = d;
    repeat (HALF / 2) @(negedge clk);
    aud_bck = 1'b1;
    repeat (4) @(negedge clk);
    if (junk) aud_sd = ~d;
    repeat (HALF - 4) @(negedge clk);
  endtask

  task automatic send_slot(input logic ws, input bit i2s, input int n, input logic [23:0] w);
    for (int k = 0; k < SLOT; k++) begin
      logic b;
      b = k[0];
      if (i2s) begin
        if (k >= 1 && k <= n) b = w[n - k];
      end else begin
        if (k >= SLOT - n) b = w[SLOT - 1 - k];
      end
      send_bit(ws, b);
    end
  endtask

  task automatic grp(input string req, input bit i2s, input logic [1:0] wl, input bit swap,
                     input bit jk, input logic [23:0] l0, input logic [23:0] r0,
                     input logic [23:0] l1, input logic [23:0] r1);
    int   n;
    logic lws;
    n   = (wl == 2'b00) ? 16 : (wl == 2'b01) ? 20 : 24;
    lws = ~swap;
    rst = 1'b1;
    cfg_i2s = i2s;
    cfg_wlen = wl;
    cfg_lr_swap = swap;
    junk = jk;
    aud_bck = 1'b0;
    aud_ws = ~lws;
    repeat (8) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cur_req = req;
    check(pair_valid == 1'b0, "R1", "valid after reset", {23'h0, pair_valid}, 24'h0);
    check(left_out == 24'h0, "R1", "left after reset", left_out, 24'h0);
    check(right_out == 24'h0, "R1", "right after reset", right_out, 24'h0);
    // idle in the right phase: the partial word it ends must not pair (R9)
    repeat (6) send_bit(~lws, 1'b1);
    exp_q.push_back({ext(l0, n), ext(r0, n)});
    send_slot(lws, i2s, n, l0);
    send_slot(~lws, i2s, n, r0);
    exp_q.push_back({ext(l1, n), ext(r1, n)});
    send_slot(lws, i2s, n, l1);
    send_slot(~lws, i2s, n, r1);
    repeat (4) send_bit(lws, 1'b0);
    repeat (50) @(negedge clk);
    check(exp_q.size() == 0, "R7", "pairs still pending", 24'(exp_q.size()), 24'h0);
    exp_q.delete();
  endtask

  initial begin
    // R2: right-justified 16-bit, R5 negative values
    grp("R2", 1'b0, 2'b00, 1'b0, 1'b0, 24'h008001, 24'h007FFF, 24'h001234, 24'h00FEDC);
    // R6: reversed polarity, 20-bit right-justified
    grp("R6", 1'b0, 2'b01, 1'b1, 1'b0, 24'h080000, 24'h012345, 24'h0FFFFF, 24'h07FFFF);
    // R4: 24-bit, then reserved code treated as 24
    grp("R4", 1'b0, 2'b10, 1'b0, 1'b0, 24'h800000, 24'h123456, 24'hABCDEF, 24'h7FFFFF);
    grp("R4", 1'b0, 2'b11, 1'b1, 1'b0, 24'hC00001, 24'h3FFFFE, 24'h000001, 24'hFFFFFF);
    // R3: I2S framing at several lengths
    grp("R3", 1'b1, 2'b00, 1'b0, 1'b0, 24'h00A55A, 24'h005AA5, 24'h00FFFF, 24'h000000);
    grp("R3", 1'b1, 2'b10, 1'b1, 1'b0, 24'h876543, 24'h0F0F0F, 24'hFFFFFE, 24'h400000);
    // R5: 20-bit I2S sign extension
    grp("R5", 1'b1, 2'b01, 1'b0, 1'b0, 24'h0FFFFF, 24'h080001, 24'h07FFFF, 24'h0C3C3C);
    // R8: data scrambled during the high phase
    grp("R8", 1'b1, 2'b01, 1'b0, 1'b1, 24'h0ABCDE, 24'h054321, 24'h080000, 24'h000011);
    grp("R8", 1'b0, 2'b00, 1'b1, 1'b1, 24'h00C0DE, 24'h00BEEF, 24'h000001, 24'h008000);
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule